// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block sits in front of a small shared memory and gives several requesting ports atomic read-modify-write through a reservation scheme. A port issues a load-linked to read a word and arm a reservation on that address. It later issues a store-conditional to the same address. The conditional store writes only if no committed store from another port has touched that address in between. The response tells the requester whether the store landed. On a failure the requester repeats the whole read, compute and conditional-store sequence. Plain loads and plain stores are also served, and a plain store counts as a committed store when other ports' reservations are checked.

Each port has a valid/ready request channel carrying an operation code, an address and write data. The block serves one request at a time. A fixed-priority arbiter picks the lowest-numbered requesting port. The control state machine has three states:
- `ST_IDLE` accepts the granted request.
- `ST_EXEC` performs the memory access and updates the reservations.
- `ST_RESP` presents the response for one cycle.

Its transitions are:
- IDLE→EXEC when any request is pending.
- EXEC→RESP unconditionally.
- RESP→IDLE unconditionally.

Each port holds exactly one reservation, made of a valid flag and an address.

Top module: `resv_monitor`

## Requirements
- R1: After reset no response is valid, no request is accepted without a pending request, every reservation is invalid and every memory word reads 0.
- R2: Operation code 2'b00 (plain load) returns the stored word with rsp_ok=1. Code 2'b01 (plain store) writes the word, returns rsp_ok=1 and returns rsp_rdata=0.
- R3: Code 2'b10 (load-linked) returns the current word with rsp_ok=1 and arms the issuing port's reservation on that address.
- R4: Code 2'b11 (store-conditional) with a valid reservation of the issuing port on the same address writes the word and returns rsp_ok=1 and rsp_rdata=0.
- R5: A store-conditional without a valid matching reservation returns rsp_ok=0 and leaves memory unchanged.
- R6: A committed store from one port breaks every other port's reservation on the same address. A committed store is a plain store or a successful store-conditional. A store to a different address leaves the reservation intact.
- R7: A store-conditional clears the issuing port's reservation whether it succeeds or fails.
- R8: A store-conditional to an address other than the one reserved fails.
- R9: A new load-linked replaces the port's earlier reservation.
- R10: A plain store from a port does not break that same port's reservation.
- R11: When requests are pending on several ports at once, the lowest-numbered port is accepted first. Of two simultaneous store-conditionals to one reserved address, only the first served succeeds.
- R12: A request is accepted (req_ready, one-hot) in the idle cycle it is pending. Its response is valid on exactly one port for one cycle, two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NP | Request pending, one bit per port |
| req_ready | output | NP | Request accepted this cycle, one-hot |
| req_op | input | 2*NP | Operation code per port (00 load, 01 store, 10 load-linked, 11 store-conditional) |
| req_addr | input | AW*NP | Word address per port |
| req_wdata | input | DW*NP | Write data per port |
| rsp_valid | output | NP | Response valid, one-hot on the served port |
| rsp_rdata | output | DW | Read data for loads, 0 for stores |
| rsp_ok | output | 1 | Success flag (0 only for a failed store-conditional) |

## Verification
The hardest case to reach from the ports is two store-conditionals to one address arriving in the same cycle, with both ports already holding a reservation there. The stimulus arms both reservations with consecutive load-linked requests. It then launches both conditional stores from two concurrent processes on the same clock edge, so the arbiter must order them. The first winner's commit must then break the loser's reservation before the loser executes. Reservation breaking, replacement and address mismatch are exercised by a sequential vector table in which each conditional store is followed by a plain load of the target word.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_LINK  = 2'b10,
        OP_COND  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_EXEC = 2'b01,
        ST_RESP = 2'b10
    } state_e;

endpackage

// File: rtl/resv_arb.sv
module resv_arb #(
    parameter int NP = 2,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0] req,
    output logic [NP-1:0] grant,
    output logic [IW-1:0] idx,
    output logic          any
);

    // lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/resv_table.sv
module resv_table #(
    parameter int NP = 2,
    parameter int AW = 4,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic [AW-1:0] set_addr,
    input  logic          own_clr_en,
    input  logic [IW-1:0] own_clr_idx,
    input  logic          snoop_en,
    input  logic [IW-1:0] snoop_src,
    input  logic [AW-1:0] snoop_addr,
    input  logic [IW-1:0] query_idx,
    input  logic [AW-1:0] query_addr,
    output logic          query_hit,
    output logic [NP-1:0] valid_vec
);

    logic [AW-1:0] addr_q [NP];

    for (genvar i = 0; i < NP; i++) begin : g_slot
        logic          v_q;
        logic [AW-1:0] a_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                a_q <= '0;
            end else if (set_en && set_idx == IW'(i)) begin
                v_q <= 1'b1;
                a_q <= set_addr;
            end else if (own_clr_en && own_clr_idx == IW'(i)) begin
                v_q <= 1'b0;
            end else if (snoop_en && snoop_src != IW'(i) && v_q && a_q == snoop_addr) begin
                v_q <= 1'b0;
            end
        end

        assign valid_vec[i] = v_q;
        assign addr_q[i]    = a_q;
    end

    assign query_hit = valid_vec[query_idx] && (addr_q[query_idx] == query_addr);

endmodule

// File: rtl/resv_mem.sv
module resv_mem #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int NP = 2,
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    req_valid,
    output logic [NP-1:0]    req_ready,
    input  logic [2*NP-1:0]  req_op,
    input  logic [AW*NP-1:0] req_addr,
    input  logic [DW*NP-1:0] req_wdata,
    output logic [NP-1:0]    rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_ok
);

    state_e        state_q, state_d;
    logic [NP-1:0] grant;
    logic [IW-1:0] gidx;
    logic          gany;

    op_e           cur_op;
    logic [IW-1:0] cur_idx;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;
    logic [DW-1:0] rd_q;
    logic          ok_q;

    logic          in_exec;
    logic          exec_cond;
    logic          exec_link;
    logic          resv_hit;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic [NP-1:0] resv_valid;

    resv_arb #(.NP(NP)) arb_i (
        .req   (req_valid),
        .grant (grant),
        .idx   (gidx),
        .any   (gany)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (gany) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- request capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_op    <= OP_READ;
            cur_idx   <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (state_q == ST_IDLE && gany) begin
            cur_op    <= op_e'(req_op[32'(gidx) * 2 +: 2]);
            cur_idx   <= gidx;
            cur_addr  <= req_addr[32'(gidx) * AW +: AW];
            cur_wdata <= req_wdata[32'(gidx) * DW +: DW];
        end
    end

    // ---------------- execution ----------------
    assign in_exec   = (state_q == ST_EXEC);
    assign exec_cond = in_exec && (cur_op == OP_COND);
    assign exec_link = in_exec && (cur_op == OP_LINK);
    assign mem_we    = in_exec && ((cur_op == OP_WRITE) || (cur_op == OP_COND && resv_hit));

    resv_mem #(.AW(AW), .DW(DW)) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (cur_addr),
        .wdata (cur_wdata),
        .rdata (mem_rdata)
    );

    resv_table #(.NP(NP), .AW(AW)) table_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (exec_link),
        .set_idx     (cur_idx),
        .set_addr    (cur_addr),
        .own_clr_en  (exec_cond),
        .own_clr_idx (cur_idx),
        .snoop_en    (mem_we),
        .snoop_src   (cur_idx),
        .snoop_addr  (cur_addr),
        .query_idx   (cur_idx),
        .query_addr  (cur_addr),
        .query_hit   (resv_hit),
        .valid_vec   (resv_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
            ok_q <= 1'b0;
        end else if (in_exec) begin
            rd_q <= (cur_op == OP_READ || cur_op == OP_LINK) ? mem_rdata : '0;
            ok_q <= (cur_op == OP_COND) ? resv_hit : 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready = '0;
        rsp_valid = '0;
        rsp_rdata = '0;
        rsp_ok    = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = grant;
            ST_EXEC: ;
            ST_RESP: begin
                rsp_valid[cur_idx] = 1'b1;
                rsp_rdata          = rd_q;
                rsp_ok             = ok_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int NP = 2,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] req_valid,
    input logic [NP-1:0] req_ready,
    input logic [NP-1:0] rsp_valid,
    input logic          exec_cond,
    input logic          exec_hit,
    input logic          mem_we,
    input logic [IW-1:0] exec_idx,
    input logic [NP-1:0] resv_valid
);

    // R12
    ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    // R12
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    // R12
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    // R12
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> ##1 (rsp_valid == $past(req_ready, 2)));

    // R11
    low_port_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |-> ((req_ready & ~NP'(1)) == '0));

    // R5
    fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_cond && !exec_hit) |-> !mem_we);

    // R4
    pass_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_cond && exec_hit) |-> mem_we);

    // R7
    cond_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_cond |=> !resv_valid[$past(exec_idx)]);

endmodule

bind resv_monitor resv_monitor_chk #(.NP(NP)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .exec_cond  (exec_cond),
    .exec_hit   (resv_hit),
    .mem_we     (mem_we),
    .exec_idx   (cur_idx),
    .resv_valid (resv_valid)
);

// File: tb/resv_monitor_tb_top.sv
`timescale 1ns/1ps
module resv_monitor_tb_top;

    localparam int NP = 2;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NV = 33;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    req_valid = '0;
    logic [NP-1:0]    req_ready;
    logic [2*NP-1:0]  req_op = '0;
    logic [AW*NP-1:0] req_addr = '0;
    logic [DW*NP-1:0] req_wdata = '0;
    logic [NP-1:0]    rsp_valid;
    logic [DW-1:0]    rsp_rdata;
    logic             rsp_ok;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    resv_monitor #(.NP(NP), .AW(AW), .DW(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_ok    (rsp_ok)
    );

    // {port, op, addr, wdata, expected rdata, expected ok}
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 2'd0, 4'h3, 8'h00, 8'h00, 1'b1},
        {1'b0, 2'd1, 4'h3, 8'h55, 8'h00, 1'b1},
        {1'b0, 2'd0, 4'h3, 8'h00, 8'h55, 1'b1},
        {1'b0, 2'd2, 4'h3, 8'h00, 8'h55, 1'b1},
        {1'b0, 2'd3, 4'h3, 8'h56, 8'h00, 1'b1},
        {1'b0, 2'd0, 4'h3, 8'h00, 8'h56, 1'b1},
        {1'b0, 2'd3, 4'h3, 8'h77, 8'h00, 1'b0},
        {1'b0, 2'd0, 4'h3, 8'h00, 8'h56, 1'b1},
        {1'b0, 2'd2, 4'h3, 8'h00, 8'h56, 1'b1},
        {1'b1, 2'd1, 4'h3, 8'h11, 8'h00, 1'b1},
        {1'b0, 2'd3, 4'h3, 8'h22, 8'h00, 1'b0},
        {1'b0, 2'd0, 4'h3, 8'h00, 8'h11, 1'b1},
        {1'b1, 2'd2, 4'h5, 8'h00, 8'h00, 1'b1},
        {1'b0, 2'd1, 4'h6, 8'h33, 8'h00, 1'b1},
        {1'b1, 2'd3, 4'h5, 8'h44, 8'h00, 1'b1},
        {1'b1, 2'd0, 4'h5, 8'h00, 8'h44, 1'b1},
        {1'b0, 2'd2, 4'h7, 8'h00, 8'h00, 1'b1},
        {1'b0, 2'd3, 4'h8, 8'h99, 8'h00, 1'b0},
        {1'b0, 2'd0, 4'h8, 8'h00, 8'h00, 1'b1},
        {1'b0, 2'd2, 4'h2, 8'h00, 8'h00, 1'b1},
        {1'b0, 2'd2, 4'h4, 8'h00, 8'h00, 1'b1},
        {1'b0, 2'd3, 4'h2, 8'h12, 8'h00, 1'b0},
        {1'b0, 2'd0, 4'h2, 8'h00, 8'h00, 1'b1},
        {1'b1, 2'd2, 4'h9, 8'h00, 8'h00, 1'b1},
        {1'b1, 2'd1, 4'h9, 8'h21, 8'h00, 1'b1},
        {1'b1, 2'd3, 4'h9, 8'h31, 8'h00, 1'b1},
        {1'b1, 2'd0, 4'h9, 8'h00, 8'h31, 1'b1},
        {1'b0, 2'd2, 4'hA, 8'h00, 8'h00, 1'b1},
        {1'b1, 2'd2, 4'hA, 8'h00, 8'h00, 1'b1},
        {1'b1, 2'd3, 4'hA, 8'h41, 8'h00, 1'b1},
        {1'b0, 2'd3, 4'hA, 8'h42, 8'h00, 1'b0},
        {1'b0, 2'd0, 4'hA, 8'h00, 8'h41, 1'b1},
        {1'b0, 2'd3, 4'h1, 8'h50, 8'h00, 1'b0}
    };

    string vtag [NV] = '{
        "R1", "R2", "R2", "R3", "R4", "R4", "R7", "R5", "R3", "R6", "R6",
        "R6", "R3", "R2", "R6", "R6", "R3", "R8", "R8", "R3", "R9", "R9",
        "R9", "R3", "R10", "R10", "R10", "R3", "R3", "R4", "R6", "R6", "R5"
    };

    task automatic check(input bit cond, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] rd,
                          output logic ok, output time t_rsp);
        @(negedge clk);
        req_op[p*2 +: 2]     = op;
        req_addr[p*AW +: AW] = a;
        req_wdata[p*DW +: DW] = d;
        req_valid[p]         = 1'b1;
        #1;
        while (!req_ready[p]) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid[p] = 1'b0;
        #1;
        while (!rsp_valid[p]) begin
            @(negedge clk);
            #1;
        end
        rd    = rsp_rdata;
        ok    = rsp_ok;
        t_rsp = $time;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd0, rd1;
        logic          ok0, ok1;
        time           t0, t1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, nothing accepted, nothing answered
        check(rsp_valid == '0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(req_ready == '0, "R1", "req_ready with no request", req_ready, 0);

        for (int i = 0; i < NV; i++) begin
            run_op(int'(VEC[i][23]), VEC[i][22:21], VEC[i][20:17], VEC[i][16:9], rd0, ok0, t0);
            check(rd0 == VEC[i][8:1], vtag[i], $sformatf("vector %0d rdata", i), rd0, VEC[i][8:1]);
            check(ok0 == VEC[i][0], vtag[i], $sformatf("vector %0d ok", i), ok0, VEC[i][0]);
        end

        // R11: both ports reserve 0xB, then race conditional stores
        run_op(0, 2'd2, 4'hB, 8'h00, rd0, ok0, t0);
        run_op(1, 2'd2, 4'hB, 8'h00, rd1, ok1, t1);
        fork
            run_op(0, 2'd3, 4'hB, 8'hA0, rd0, ok0, t0);
            run_op(1, 2'd3, 4'hB, 8'hB0, rd1, ok1, t1);
        join
        check(t0 < t1, "R11", "port 0 answered first", int'(t0), int'(t1));
        check(ok0 == 1'b1, "R11", "first conditional store ok", ok0, 1);
        check(ok1 == 1'b0, "R11", "second conditional store ok", ok1, 0);
        run_op(1, 2'd0, 4'hB, 8'h00, rd1, ok1, t1);
        check(rd1 == 8'hA0, "R11", "word after race", rd1, 8'hA0);

        // R11: simultaneous plain loads are both served, port 0 first
        fork
            run_op(0, 2'd0, 4'h3, 8'h00, rd0, ok0, t0);
            run_op(1, 2'd0, 4'h9, 8'h00, rd1, ok1, t1);
        join
        check(t0 < t1, "R11", "load order", int'(t0), int'(t1));
        check(rd1 == 8'h31, "R11", "second port load data", rd1, 8'h31);

        // R1: reset drops a reservation and clears memory
        run_op(0, 2'd2, 4'hC, 8'h00, rd0, ok0, t0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_op(0, 2'd3, 4'hC, 8'h66, rd0, ok0, t0);
        check(ok0 == 1'b0, "R1", "conditional store after reset", ok0, 0);
        run_op(0, 2'd0, 4'h3, 8'h00, rd0, ok0, t0);
        check(rd0 == 8'h00, "R1", "memory after reset", rd0, 0);

        // R12: response appears exactly two edges after acceptance
        @(negedge clk);
        req_op[1:0] = 2'd0;
        req_addr[AW-1:0] = 4'h0;
        req_valid[0] = 1'b1;
        #1;
        check(req_ready == 2'b01, "R12", "accepted in idle cycle", req_ready, 1);
        @(negedge clk);
        req_valid[0] = 1'b0;
        #1;
        check(rsp_valid == '0, "R12", "no response one cycle later", rsp_valid, 0);
        @(negedge clk);
        #1;
        check(rsp_valid == 2'b01, "R12", "response two cycles later", rsp_valid, 1);
        @(negedge clk);
        #1;
        check(rsp_valid == '0, "R12", "response lasts one cycle", rsp_valid, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule